// File: doc/BRIEF.md
# Banked-Accumulator Subtract/Shift ALU

This block is the arithmetic slice of a small 8-bit controller that handles two instruction kinds. The first is a reverse subtract: the active accumulator, and optionally the incoming carry used as a borrow, is taken away from a source operand. The second is a logical left shift of the source operand by an immediate count from 0 to 7. The register-bank select input chooses which of the accumulators is the active operand. All accumulator values come in on one packed bus.

Each operation is presented for one cycle. One clock edge later the result appears on the outputs, together with a write-enable strobe and the N, Z, C and V flags. The surrounding controller writes the result back and feeds the stored carry and overflow flags in again. This lets a multi-byte subtraction run as a plain subtract on the low byte, followed by borrow-chained subtracts on the higher bytes.

Top module: `bank_alu`

## Requirements
- R1: After reset, `resData`, `resWe`, `flagN`, `flagZ`, `flagC` and `flagV` are all 0.
- R2: With `opValid`=1 and `opCode`=2'b10 (subtract with borrow), the next cycle gives `resData` = (src - acc - carryIn) mod 256, with `resWe`=1.
- R3: With `opCode`=2'b01 (plain subtract), the next cycle gives `resData` = (src - acc) mod 256, and `carryIn` has no effect.
- R4: After a subtract, `flagC` is 1 exactly when acc plus the borrow actually used, taken as unsigned numbers, is greater than src.
- R5: After a subtract, `flagV` is 1 exactly when src and acc differ in bit 7 and the result's bit 7 differs from src bit 7.
- R6: After every executed operation, `flagN` equals bit 7 of `resData`, and `flagZ` is 1 exactly when `resData` is zero.
- R7: `bankSel`=0 selects acc = `accIn[7:0]`, and `bankSel`=1 selects acc = `accIn[15:8]`.
- R8: With `opCode`=2'b11 (shift left) and `shiftAmt`=k in 1..7, the next cycle gives `resData` = (src << k) mod 256 with zeros filled in, and `flagC` = src bit (8-k).
- R9: A shift with `shiftAmt`=0 returns src unchanged, with `flagC`=0.
- R10: After a shift, `flagV` equals the `vIn` value presented with the shift.
- R11: When `opValid`=0, or when `opCode`=2'b00, the next cycle has `resWe`=0, and the result and all flags keep their previous values.
- R12: A plain subtract on the low bytes, followed by a borrow subtract on the high bytes that takes the low step's `flagC` as its carry, yields the 16-bit difference. The final `flagC` is then 1 exactly when the 16-bit subtrahend is greater than the minuend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 2 | 00 idle, 01 subtract, 10 subtract with borrow, 11 shift left |
| srcData | input | 8 | Source operand |
| accIn | input | 16 | Accumulator values, bank 0 in the low byte |
| bankSel | input | 1 | Active accumulator select |
| shiftAmt | input | 3 | Immediate shift count |
| carryIn | input | 1 | Current carry flag (borrow) |
| vIn | input | 1 | Current overflow flag, passed through on shifts |
| resData | output | 8 | Registered result |
| resWe | output | 1 | Result write strobe |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / borrow flag |
| flagV | output | 1 | Overflow flag |

## Verification
The assertions assume that `bankSel` always names an accumulator that exists, and that the operand inputs hold steady during the cycle in which an operation is presented. The stimulus changes every input only at the falling edge, and it uses only bank values 0 and 1. On top of this, the sweeps alternate the bank while they run through every source byte, a strided set of accumulator values, both carry values and all eight shift counts. Idle cycles carry deliberately scrambled operands, so that any leak into the held outputs would show up.

// File: rtl/bank_alu_pkg.sv
package bank_alu_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_SUB  = 2'b01,
    OP_SBC  = 2'b10,
    OP_SHL  = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // commit result and flags
    logic doSub;     // subtract path
    logic useCarry;  // include borrow
    logic doShl;     // shift path
  } aluStb_t;

endpackage

// File: rtl/bank_alu_ctrl.sv
module bank_alu_ctrl
  import bank_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opCode,
  output aluStb_t    stb
);

  aluOp_e opDec;

  always_comb begin
    opDec = aluOp_e'(opCode);
    stb = '0;
    if (opValid) begin
      unique case (opDec)
        OP_SUB: begin
          stb.wrEn  = 1'b1;
          stb.doSub = 1'b1;
        end
        OP_SBC: begin
          stb.wrEn     = 1'b1;
          stb.doSub    = 1'b1;
          stb.useCarry = 1'b1;
        end
        OP_SHL: begin
          stb.wrEn  = 1'b1;
          stb.doShl = 1'b1;
        end
        default: stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/bank_alu_dp.sv
module bank_alu_dp
  import bank_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_ACC = 2,
  localparam int BANK_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int SHIFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  aluStb_t                   stb,
  input  logic [DATA_W-1:0]         srcData,
  input  logic [NUM_ACC*DATA_W-1:0] accIn,
  input  logic [BANK_W-1:0]         bankSel,
  input  logic [SHIFT_W-1:0]        shiftAmt,
  input  logic                      carryIn,
  input  logic                      vIn,
  output logic [DATA_W-1:0]         resData,
  output logic                      resWe,
  output logic                      flagN,
  output logic                      flagZ,
  output logic                      flagC,
  output logic                      flagV
);

  localparam int WIDE_W = 2 * DATA_W;

  // accumulator bank mux
  logic [DATA_W-1:0] accBank [NUM_ACC];
  logic [DATA_W-1:0] accSel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ACC; gi++) begin : g_bank
      assign accBank[gi] = accIn[gi*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    accSel = accBank[0];
    for (int i = 1; i < NUM_ACC; i++) begin
      if (bankSel == BANK_W'(i)) accSel = accBank[i];
    end
  end

  // reverse subtract: src - acc - borrow
  logic              borrowUsed;
  logic [DATA_W:0]   subWide;
  logic [DATA_W-1:0] subRes;
  logic              subC;
  logic              subV;

  always_comb begin
    borrowUsed = stb.useCarry & carryIn;
    subWide = {1'b0, srcData} - {1'b0, accSel} - {{DATA_W{1'b0}}, borrowUsed};
    subRes  = subWide[DATA_W-1:0];
    subC    = subWide[DATA_W];
    subV    = (srcData[DATA_W-1] ^ accSel[DATA_W-1]) &
              (subRes[DATA_W-1] ^ srcData[DATA_W-1]);
  end

  // staged left shifter on a double-width word; bit DATA_W is the last bit out
  logic [WIDE_W-1:0] shStage [SHIFT_W+1];
  assign shStage[0] = {{DATA_W{1'b0}}, srcData};

  generate
    for (gi = 0; gi < SHIFT_W; gi++) begin : g_shift
      assign shStage[gi+1] = shiftAmt[gi] ? (shStage[gi] << (1 << gi)) : shStage[gi];
    end
  endgenerate

  logic [DATA_W-1:0] shlRes;
  logic              shlC;
  assign shlRes = shStage[SHIFT_W][DATA_W-1:0];
  assign shlC   = shStage[SHIFT_W][DATA_W];

  // result select and flag staging
  logic [DATA_W-1:0] nextRes;
  logic              nextC;
  logic              nextV;

  always_comb begin
    if (stb.doShl) begin
      nextRes = shlRes;
      nextC   = shlC;
      nextV   = vIn;
    end else begin
      nextRes = subRes;
      nextC   = subC;
      nextV   = subV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resWe   <= 1'b0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
      flagV   <= 1'b0;
    end else begin
      resWe <= stb.wrEn;
      if (stb.wrEn) begin
        resData <= nextRes;
        flagN   <= nextRes[DATA_W-1];
        flagZ   <= (nextRes == '0);
        flagC   <= nextC;
        flagV   <= nextV;
      end
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> (!resWe && $stable(resData) && $stable(flagC) && $stable(flagV))); // R11

  AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doSub && srcData == accSel && !borrowUsed) |=> (flagZ && !flagC && !flagV)); // R4

  AST_SHL_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doShl && shiftAmt == '0) |=> (resData == $past(srcData) && !flagC)); // R9

  AST_SHL_KEEPS_V: assert property (@(posedge clk) disable iff (!rstN)
    stb.doShl |=> (flagV == $past(vIn))); // R10

  AST_SUB_PLAIN_NO_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doSub && !stb.useCarry) |=> (resData == $past(srcData - accSel))); // R3

  AST_NEG_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> (flagN == resData[DATA_W-1])); // R6

endmodule

// File: rtl/bank_alu.sv
module bank_alu
  import bank_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_ACC = 2,
  localparam int BANK_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int SHIFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      opValid,
  input  logic [1:0]                opCode,
  input  logic [DATA_W-1:0]         srcData,
  input  logic [NUM_ACC*DATA_W-1:0] accIn,
  input  logic [BANK_W-1:0]         bankSel,
  input  logic [SHIFT_W-1:0]        shiftAmt,
  input  logic                      carryIn,
  input  logic                      vIn,
  output logic [DATA_W-1:0]         resData,
  output logic                      resWe,
  output logic                      flagN,
  output logic                      flagZ,
  output logic                      flagC,
  output logic                      flagV
);

  aluStb_t stb;

  bank_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .stb     (stb)
  );

  bank_alu_dp #(
    .DATA_W  (DATA_W),
    .NUM_ACC (NUM_ACC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcData  (srcData),
    .accIn    (accIn),
    .bankSel  (bankSel),
    .shiftAmt (shiftAmt),
    .carryIn  (carryIn),
    .vIn      (vIn),
    .resData  (resData),
    .resWe    (resWe),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV)
  );

  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != 2'b00) |=> resWe); // R2

endmodule

// File: tb/bank_alu_tb.sv
module bank_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [7:0]  srcData = 8'h00;
  logic [15:0] accIn = 16'h0000;
  logic        bankSel = 1'b0;
  logic [2:0]  shiftAmt = 3'd0;
  logic        carryIn = 1'b0;
  logic        vIn = 1'b0;
  logic [7:0]  resData;
  logic        resWe, flagN, flagZ, flagC, flagV;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bank_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcData(srcData), .accIn(accIn), .bankSel(bankSel), .shiftAmt(shiftAmt),
    .carryIn(carryIn), .vIn(vIn), .resData(resData), .resWe(resWe),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one op at the falling edge, then sample at the next falling edge
  task automatic runOp(int op, int src, int acc, int bank, int cin, int amt, int vi);
    opValid  = 1'b1;
    opCode   = op[1:0];
    srcData  = src[7:0];
    bankSel  = bank[0];
    accIn    = bank[0] ? {acc[7:0], ~acc[7:0]} : {~acc[7:0], acc[7:0]};
    carryIn  = cin[0];
    shiftAmt = amt[2:0];
    vIn      = vi[0];
    @(negedge clk);
  endtask

  task automatic checkCommon(int res);
    chk("R6 N", int'(flagN), (res >> 7) & 1);
    chk("R6 Z", int'(flagZ), (res == 0) ? 1 : 0);
  endtask

  task automatic subCase(int op, int src, int acc, int bank, int cin);
    int b, d, res, c, v;
    runOp(op, src, acc, bank, cin, 3, 1);
    b   = (op == 2) ? cin : 0;
    d   = src - acc - b;
    res = d & 255;
    c   = (acc + b > src) ? 1 : 0;
    v   = (((src ^ acc) & 128) != 0 && ((src ^ res) & 128) != 0) ? 1 : 0;
    chk((op == 2) ? "R2 R7 result" : "R3 R7 result", int'(resData), res);
    chk("R2 we", int'(resWe), 1);
    chk("R4 C", int'(flagC), c);
    chk("R5 V", int'(flagV), v);
    checkCommon(res);
  endtask

  task automatic shlCase(int src, int amt, int vi, int bank);
    int res, c;
    runOp(3, src, 8'h5A, bank, 1, amt, vi);
    res = (src << amt) & 255;
    c   = (amt == 0) ? 0 : ((src >> (8 - amt)) & 1);
    chk((amt == 0) ? "R9 result" : "R8 result", int'(resData), res);
    chk((amt == 0) ? "R9 C" : "R8 C", int'(flagC), c);
    chk("R10 V", int'(flagV), vi);
    checkCommon(res);
  endtask

  task automatic idleCase(int useNopCode);
    logic [7:0] r;
    logic n, z, c, v;
    r = resData; n = flagN; z = flagZ; c = flagC; v = flagV;
    opValid  = useNopCode ? 1'b1 : 1'b0;
    opCode   = useNopCode ? 2'b00 : 2'b11;
    srcData  = ~r;
    accIn    = {r, r + 8'd1};
    carryIn  = ~c;
    vIn      = ~v;
    shiftAmt = 3'd5;
    @(negedge clk);
    chk("R11 we", int'(resWe), 0);
    chk("R11 result", int'(resData), int'(r));
    chk("R11 flags", int'({flagN, flagZ, flagC, flagV}), int'({n, z, c, v}));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int a16, b16, lo, hi, clo;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 result", int'(resData), 0);
    chk("R1 flags", int'({resWe, flagN, flagZ, flagC, flagV}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // subtract sweeps (R2 R3 R4 R5 R7)
    for (int op = 1; op <= 2; op++)
      for (int src = 0; src < 256; src++)
        for (int acc = 0; acc < 256; acc += 17)
          for (int cin = 0; cin < 2; cin++)
            subCase(op, src, acc, (src + acc) & 1, cin);
    // corner values
    subCase(2, 0, 255, 0, 1);
    subCase(2, 128, 1, 1, 0);
    subCase(2, 127, 255, 0, 0);
    subCase(1, 0, 0, 1, 1);
    subCase(2, 0, 0, 1, 1);

    // shift sweep (R8 R9 R10)
    for (int src = 0; src < 256; src++)
      for (int amt = 0; amt < 8; amt++)
        shlCase(src, amt, (src ^ amt) & 1, amt & 1);

    // idle handling (R11)
    subCase(2, 200, 3, 1, 1);
    idleCase(0);
    idleCase(1);
    shlCase(8'h81, 1, 1, 0);
    idleCase(0);
    idleCase(1);

    // 16-bit chaining (R12)
    for (int i = 0; i < 300; i++) begin
      a16 = (i * 40503 + 7) & 16'hFFFF;
      b16 = (i * 9973 + 12345) & 16'hFFFF;
      if (i == 0) begin a16 = 16'h0100; b16 = 16'h0001; end
      if (i == 1) begin a16 = 16'h0000; b16 = 16'h0001; end
      runOp(1, a16 & 255, b16 & 255, 0, 1, 0, 0);
      lo  = int'(resData);
      clo = int'(flagC);
      runOp(2, (a16 >> 8) & 255, (b16 >> 8) & 255, 1, clo, 0, 0);
      hi  = int'(resData);
      chk("R12 diff", (hi << 8) | lo, (a16 - b16) & 16'hFFFF);
      chk("R12 C", int'(flagC), (b16 > a16) ? 1 : 0);
    end

    opValid = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule